// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one read or write burst for a synchronous DRAM. A one-cycle start strobe loads a start column, a 3-bit burst-length code and a one-bit ordering select. Starting in the next cycle, the block presents one column address per clock. Each address comes with a valid flag, and the final beat also carries a last flag.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside an aligned block of columns. The block's size equals the burst length, and the column bits above that block never change during the burst. The offset within the block either counts upward and wraps, or is the start offset XOR the beat index.

A page-length burst steps upward through every column of the page and wraps to column 0 at the page boundary. It has no end of its own and stops only when the terminate input is raised. A reserved length code, or a page-length burst requested with XOR ordering, makes no accesses and raises a one-cycle error flag instead.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are low, and `err_o` is never high in a cycle where `valid_o` is high.
- R2: A legal start presents `start_col_i` on `col_o` with `valid_o` high in the cycle after the strobe, and one new address follows in each later cycle until the burst ends.
- R3: With `itl_i`=0 and a fixed length N, beat k carries the column whose bits above log2(N) equal those of the start column and whose low log2(N) bits are (start offset + k) mod N.
- R4: With `itl_i`=1 and a fixed length N, beat k carries the same upper bits as the start column, and its low log2(N) bits are the start offset XOR k.
- R5: `len_code_i` 000, 001, 010 and 011 select 1, 2, 4 and 8 beats, and 111 selects page length. `last_o` is high on the final beat of a fixed burst, and `valid_o` is low in the cycle after that beat unless a new start was given.
- R6: Code 000 yields exactly one beat, equal to the start column, with `last_o` high, for either value of `itl_i`.
- R7: A page-length burst (code 111, `itl_i`=0) increments the column by one per beat, wraps from 2^COL_W-1 to 0, and never raises `last_o` by itself.
- R8: While `valid_o` is high, a high `term_i` raises `last_o` in that same cycle, and no further valid beats follow.
- R9: A start with codes 100, 101 or 110, or with code 111 and `itl_i`=1, raises `err_o` for exactly one cycle, holds `valid_o` low, and aborts any burst in progress.
- R10: A legal start accepted while a burst is running abandons that burst, and the new burst begins in the next cycle from the new start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle strobe that begins a burst |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst-length code |
| itl_i | input | 1 | Ordering select: 0 counts upward, 1 uses XOR |
| term_i | input | 1 | Ends the running burst at the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | The current beat is valid |
| last_o | output | 1 | The current beat is the final one |
| err_o | output | 1 | The previous start requested an illegal mode |

## Verification
The bench targets the wrap point inside the aligned block. A design that carried the offset into the upper bits would leave the block at starts such as 5 with length 8.

Under XOR ordering, a design that counted upward would produce 5-6-7 where 5-4-7 is required. In a page-length burst that crosses column 511, a truncated counter would fail to return to 0 or would raise last at the wrap.

The bench also drives terminate, restart and illegal starts in the middle of a burst. Designs that kept issuing beats, delayed the last flag by a cycle, or let an illegal start leave the old burst running are all reported.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LEN_CODE_W = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/bseq_mode_dec.sv
module bseq_mode_dec
  import burst_seq_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int MAX_LOG2 = 3
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  itl,
  output logic                  legal,
  output logic                  page,
  output logic [COL_W-1:0]      mask
);
  logic fixed_len;

  assign fixed_len = (len_code <= LEN_CODE_W'(MAX_LOG2));
  assign page      = (len_code == LEN_PAGE);
  assign legal     = fixed_len || (page && !itl);

  // Offset mask: bit i is set when the block spans more than 2^i columns.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i < MAX_LOG2) begin : g_low
      assign mask[i] = fixed_len && (LEN_CODE_W'(i) < len_code);
    end else begin : g_high
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bseq_beat_ctl.sv
module bseq_beat_ctl #(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [BEAT_W-1:0] span,
  output logic [BEAT_W-1:0] beat_nxt,
  output logic              final_nxt
);
  logic [BEAT_W-1:0] beat_q;

  assign beat_nxt  = beat_q + 1'b1;
  assign final_nxt = (beat_nxt == span);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (load) begin
      beat_q <= '0;
    end else if (adv) begin
      beat_q <= beat_nxt;
    end
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input  logic [COL_W-1:0]  start_col,
  input  logic [COL_W-1:0]  cur_col,
  input  logic [COL_W-1:0]  mask,
  input  logic [BEAT_W-1:0] beat,
  input  logic              itl,
  input  logic              page,
  output logic [COL_W-1:0]  nxt_col
);
  localparam int PAD_W = COL_W - BEAT_W;

  logic [COL_W-1:0] beat_ext;
  logic [COL_W-1:0] upper;
  logic [COL_W-1:0] seq_off;
  logic [COL_W-1:0] xor_off;

  assign beat_ext = {{PAD_W{1'b0}}, beat};
  assign upper    = start_col & ~mask;
  assign seq_off  = (start_col + beat_ext) & mask;
  assign xor_off  = (start_col ^ beat_ext) & mask;

  always_comb begin
    if (page) begin
      nxt_col = cur_col + 1'b1;
    end else if (itl) begin
      nxt_col = upper | xor_off;
    end else begin
      nxt_col = upper | seq_off;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int MAX_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  itl_i,
  input  logic                  term_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic                  err_o
);
  localparam int BEAT_W = MAX_LOG2;

  logic             dec_legal, dec_page;
  logic [COL_W-1:0] dec_mask;

  logic             valid_q, last_q, err_q;
  logic [COL_W-1:0] col_q, start_q, mask_q;
  logic             itl_q, page_q;
  logic [BEAT_W-1:0] span_q;

  logic [BEAT_W-1:0] beat_nxt;
  logic              final_nxt;
  logic [COL_W-1:0]  nxt_col;
  logic              stop, adv, load;

  bseq_mode_dec #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) dec_i (
    .len_code (len_code_i),
    .itl      (itl_i),
    .legal    (dec_legal),
    .page     (dec_page),
    .mask     (dec_mask)
  );

  assign stop = last_q || term_i;
  assign load = start_i;
  assign adv  = !start_i && valid_q && !stop;

  bseq_beat_ctl #(.BEAT_W(BEAT_W)) beat_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .adv       (adv),
    .span      (span_q),
    .beat_nxt  (beat_nxt),
    .final_nxt (final_nxt)
  );

  bseq_addr_gen #(.COL_W(COL_W), .BEAT_W(BEAT_W)) addr_i (
    .start_col (start_q),
    .cur_col   (col_q),
    .mask      (mask_q),
    .beat      (beat_nxt),
    .itl       (itl_q),
    .page      (page_q),
    .nxt_col   (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      col_q   <= '0;
      start_q <= '0;
      mask_q  <= '0;
      itl_q   <= 1'b0;
      page_q  <= 1'b0;
      span_q  <= '0;
    end else if (start_i) begin
      err_q   <= !dec_legal;
      valid_q <= dec_legal;
      last_q  <= dec_legal && !dec_page && (dec_mask == '0);
      col_q   <= start_col_i;
      start_q <= start_col_i;
      mask_q  <= dec_mask;
      itl_q   <= itl_i;
      page_q  <= dec_page;
      span_q  <= dec_mask[BEAT_W-1:0];
    end else begin
      err_q <= 1'b0;
      if (valid_q) begin
        if (stop) begin
          valid_q <= 1'b0;
          last_q  <= 1'b0;
        end else begin
          col_q  <= nxt_col;
          last_q <= !page_q && final_nxt;
        end
      end
    end
  end

  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = valid_q && (last_q || term_i);
  assign err_o   = err_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start_i,
  input logic [COL_W-1:0]      start_col_i,
  input logic [LEN_CODE_W-1:0] len_code_i,
  input logic                  itl_i,
  input logic                  term_i,
  input logic [COL_W-1:0]      col_o,
  input logic                  valid_o,
  input logic                  last_o,
  input logic                  err_o
);
  logic ok_cfg;
  logic in_page;

  assign ok_cfg = (len_code_i <= 3'b011) || (len_code_i == 3'b111 && !itl_i);

  always_ff @(posedge clk) begin
    if (rst) in_page <= 1'b0;
    else if (start_i) in_page <= (len_code_i == 3'b111);
  end

  // R1
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && ok_cfg |=> valid_o && col_o == $past(start_col_i));

  // R5
  tail_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && last_o && !start_i |=> !valid_o);

  // R6
  single_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && len_code_i == 3'b000 |=> valid_o && last_o);

  // R7
  page_step_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && in_page && !last_o && !start_i |=> col_o == COL_W'($past(col_o) + 1'b1));

  // R8
  term_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && term_i |-> last_o);

  // R9
  illegal_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && !ok_cfg |=> err_o && !valid_o);
endmodule

bind burst_col_seq bseq_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/100ps
module burst_col_seq_tb_top;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             itl_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .itl_i(itl_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  function automatic int exp_col(int s, int code, bit itl, int k);
    int n, off, base;
    if (code == 7) return (s + k) % PAGE;
    n    = 1 << code;
    off  = s & (n - 1);
    base = s & ~(n - 1);
    return itl ? (base | (off ^ k)) : (base | ((off + k) & (n - 1)));
  endfunction

  function automatic bit is_legal(int code, bit itl);
    return (code <= 3) || (code == 7 && !itl);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit s, int c, int code, bit itl, bit term);
    @(negedge clk);
    start_i     = s;
    start_col_i = COL_W'(c);
    len_code_i  = 3'(code);
    itl_i       = itl;
    term_i      = term;
    #0.5;
  endtask

  // One whole burst; term_at < 0 means no terminate.
  task automatic run_burst(int s, int code, bit itl, int term_at);
    string tag;
    bit    t, el;
    tick(1, s, code, itl, 0);
    if (!is_legal(code, itl)) begin
      tick(0, 0, 0, 0, 0);
      chk("R9 err", err_o, 1);
      chk("R9 valid", valid_o, 0);
      tick(0, 0, 0, 0, 0);
      chk("R9 err one cycle", err_o, 0);
      chk("R9 valid stays low", valid_o, 0);
      return;
    end
    tag = (code == 7) ? "R7" : (itl ? "R4" : "R3");
    for (int k = 0; k < 4000; k++) begin
      t = (term_at == k);
      tick(0, 0, 0, 0, t);
      el = t || (code != 7 && k == (1 << code) - 1);
      chk("R2 valid", valid_o, 1);
      chk(tag, col_o, exp_col(s, code, itl, k));
      chk(t ? "R8 last" : (code == 0 ? "R6 last" : "R5 last"), last_o, el);
      if (el) break;
    end
    tick(0, 0, 0, 0, 0);
    chk("R5 R8 idle after burst", valid_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    tick(0, 0, 0, 0, 0);
    rst = 1'b0;
    #0.5;
    chk("R1 reset valid", valid_o, 0);
    chk("R1 reset last", last_o, 0);
    chk("R1 reset err", err_o, 0);

    // Directed orderings
    run_burst(5, 3, 0, -1);            // R3 5-6-7-0-1-2-3-4
    run_burst(5, 3, 1, -1);            // R4 5-4-7-6-1-0-3-2
    run_burst(2 + 64, 2, 1, -1);       // R4 2-3-0-1 with upper bits
    run_burst(3 + 128, 2, 0, -1);      // R3 wrap inside block of 4
    run_burst(1, 1, 0, -1);
    run_burst(1, 1, 1, -1);
    run_burst(77, 0, 0, -1);           // R6
    run_burst(77, 0, 1, -1);           // R6
    run_burst(508, 7, 0, 9);           // R7 wrap 511 -> 0
    run_burst(0, 7, 0, 0);             // R8 terminate first beat
    run_burst(9, 3, 1, 2);             // R8 terminate fixed burst
    run_burst(10, 4, 0, -1);           // R9 reserved codes
    run_burst(10, 5, 1, -1);
    run_burst(10, 6, 0, -1);
    run_burst(10, 7, 1, -1);           // R9 page with XOR ordering

    // R10 restart during a burst
    tick(1, 5, 3, 0, 0);
    tick(0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0);
    chk("R10 pre-restart beat", col_o, 6);
    tick(1, 200, 2, 1, 0);
    chk("R10 old beat still shown", col_o, 7);
    for (int k = 0; k < 4; k++) begin
      tick(0, 0, 0, 0, 0);
      chk("R10 new burst", col_o, exp_col(200, 2, 1, k));
      chk("R10 valid", valid_o, 1);
    end
    tick(0, 0, 0, 0, 0);
    chk("R10 ends", valid_o, 0);

    // R9 illegal start aborts a running burst
    tick(1, 0, 7, 0, 0);
    tick(0, 0, 0, 0, 0);
    tick(1, 0, 5, 0, 0);
    tick(0, 0, 0, 0, 0);
    chk("R9 abort err", err_o, 1);
    chk("R9 abort valid", valid_o, 0);
    tick(0, 0, 0, 0, 0);
    chk("R9 abort stays idle", valid_o, 0);

    // R8 terminate while idle has no effect
    tick(0, 0, 0, 0, 1);
    chk("R8 idle term last", last_o, 0);
    chk("R8 idle term valid", valid_o, 0);

    // Random legal and illegal bursts
    for (int i = 0; i < 120; i++) begin
      int  code, ta;
      bit  itl;
      code = $urandom_range(0, 7);
      itl  = 1'($urandom_range(0, 1));
      if (code == 7 && ($urandom_range(0, 3) != 0)) itl = 0;
      ta = (code == 7) ? $urandom_range(0, 700)
                       : (($urandom_range(0, 4) == 0) ? $urandom_range(0, 7) : -1);
      run_burst($urandom_range(0, PAGE - 1), code, itl, ta);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule